// File: doc/BRIEF.md
# Programmable-Rate Binomial Decimator Cascade

This block lowers the sample rate of a 24-bit signed stream by a selectable power of two, from 4 up to 256. It is a chain of eight identical decimate-by-two low-pass stages. Each stage is a 13-tap binomial filter of order 12. Only as many stages as the rate needs are active. Every tap product of every stage goes through one shared 24x24 multiplier. Each stage owns one of eight 50-bit accumulators. The rate code sets which accumulator's rounded result leaves the block; the results of the earlier accumulators are fed back into the delay line of the next stage.

A small sequencer takes an input sample into the first delay line. On every second sample that enters a stage, it runs that stage's 13 multiply-accumulate steps and then rounds the result back to 24 bits. The rounded value is either pushed into the next stage or, for the selected last stage, presented at the output. Inputs must be spaced far enough apart for a full cascade pass to finish. The rate code is taken only at reset or on a flush. A flush also clears the whole filter state.

Top module: `binom_decim_cascade`

## Requirements
- R1: Tap i (0..12) of every stage weights the sample that entered the stage i samples ago by 8192 times the binomial coefficient C(12,i). The taps are 8192, 98304, 540672, 1802240, 4055040, 6488064 and 7569408 at the centre, then mirrored.
- R2: Rate code c in 0..5 gives decimation by 2^(c+2) using c+2 stages; codes 6 and 7 both give 256 using all eight stages. out_valid pulses once per D accepted samples, D being the decimation factor, first on the D-th sample after reset or flush.
- R3: Each stage result is the 50-bit tap sum S rounded as (S + 2^24) >>> 25 (arithmetic shift), kept as 24-bit two's complement. This is exact for any legal input and never overflows.
- R4: DC gain is exactly one: after a constant input x has filled the active stages, every output equals x.
- R5: out_valid is a one-cycle pulse. It is high in the cycle that follows the 14*S-th rising edge after the edge that accepted the triggering input sample, S being the active stage count.
- R6: The rate code is latched only while rst_n is low or in a cycle with flush high; changes at other times have no effect on the output rate.
- R7: flush clears all delay lines, accumulators and stage phases, and aborts any pass in progress. The next output comes D accepted samples later and depends only on samples accepted after the flush.
- R8: While and right after reset, out_valid is 0 and out_data is 0.
- R9: An in_valid that arrives while a pass is running is ignored, so inputs must be at least 14*8+2 = 114 cycles apart to be sure of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; latches rate_sel |
| flush | input | 1 | Clears filter state and latches rate_sel |
| rate_sel | input | 3 | Rate code, decimation 2^(code+2), capped at 256 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | 24 | Signed decimated result, held until the next result |

## Verification
Each stage pass takes 14 cycles: 13 multiply-accumulate cycles and one rounding cycle. An output therefore appears exactly 14*S cycles after the accepting edge of every D-th sample, and at no other time. The bench holds each input for one edge and then watches out_valid at every falling edge of a fixed 116-cycle window. It expects a pulse only at offset 14*S, and only for the samples its own cascade model marks as output-producing. Any pulse at another offset, or a missing pulse, is reported. The value is compared against a bench-side model that builds its taps from Pascal's rule and applies the rounding rule of R3.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int DW        = 24;
  localparam int AW        = 50;
  localparam int TAPS      = 13;
  localparam int ORDER     = TAPS - 1;
  localparam int COEF_LOG2 = 13;
  localparam int NSTAGE    = 8;
  localparam int RW        = 3;
  localparam int SHIFT     = COEF_LOG2 + ORDER;
  localparam int STAGE_CYC = TAPS + 1;
  localparam int MIN_GAP   = NSTAGE * STAGE_CYC + 2;

  typedef enum logic [1:0] {ENG_IDLE, ENG_MAC, ENG_ROUND} eng_state_t;

  // scaled binomial weight of tap idx
  function automatic logic signed [DW-1:0] tap_coef(input int idx);
    longint c;
    c = 1;
    for (int j = 0; j < ORDER; j++)
      if (j < idx) c = c * longint'(ORDER - j) / longint'(j + 1);
    return DW'(c <<< COEF_LOG2);
  endfunction

  // round-half-up rescale of a stage sum
  function automatic logic signed [AW-1:0] round_wide(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] bias;
    bias = '0;
    bias[SHIFT-1] = 1'b1;
    return (acc + bias) >>> SHIFT;
  endfunction

  function automatic logic fits_out(input logic signed [AW-1:0] w);
    return (w[AW-1:DW-1] == '0) || (w[AW-1:DW-1] == '1);
  endfunction

  // active stage count for a rate code
  function automatic int stage_count(input int code, input int nst);
    return (code + 2 >= nst) ? nst : code + 2;
  endfunction
endpackage

// File: rtl/bdc_tap_line.sv
module bdc_tap_line #(
  parameter int DW   = bdc_pkg::DW,
  parameter int TAPS = bdc_pkg::TAPS,
  localparam int TW  = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic signed [DW-1:0] din,
  input  logic [TW-1:0]        rd_idx,
  output logic signed [DW-1:0] rd_data
);
  logic signed [DW-1:0] q [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < TAPS; i++) q[i] <= '0;
    end else if (push) begin
      q[0] <= din;
      for (int i = 1; i < TAPS; i++) q[i] <= q[i-1];
    end
  end

  assign rd_data = (int'(rd_idx) < TAPS) ? q[rd_idx] : '0;

  // R7: a clear leaves an all-zero history
  a_r7_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q[0] == '0) && (q[TAPS-1] == '0));
endmodule

// File: rtl/bdc_mac_bank.sv
module bdc_mac_bank #(
  parameter int DW   = bdc_pkg::DW,
  parameter int AW   = bdc_pkg::AW,
  parameter int NACC = bdc_pkg::NSTAGE,
  localparam int SW  = $clog2(NACC),
  localparam int PW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 acc_en,
  input  logic                 first,
  input  logic [SW-1:0]        sel,
  input  logic signed [DW-1:0] mul_a,
  input  logic signed [DW-1:0] mul_b,
  output logic signed [AW-1:0] acc_out
);
  logic signed [AW-1:0] acc_q [NACC];
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = mul_a * mul_b;
  assign prod_ext = AW'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
    end else if (acc_en) begin
      acc_q[sel] <= first ? prod_ext : acc_q[sel] + prod_ext;
    end
  end

  assign acc_out = acc_q[sel];

  // R3: an accumulator only changes while its slot is being driven
  a_r3_acc_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr_all) |=> $stable(acc_q[0]));
endmodule

// File: rtl/binom_decim_cascade.sv
module binom_decim_cascade #(
  parameter int DW     = bdc_pkg::DW,
  parameter int AW     = bdc_pkg::AW,
  parameter int TAPS   = bdc_pkg::TAPS,
  parameter int NSTAGE = bdc_pkg::NSTAGE,
  parameter int RW     = bdc_pkg::RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [RW-1:0] rate_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  import bdc_pkg::*;

  localparam int SW = $clog2(NSTAGE);
  localparam int TW = $clog2(TAPS);
  localparam int CW = $clog2(NSTAGE + 1);

  eng_state_t           st;
  logic [SW-1:0]        stg;
  logic [SW-1:0]        stg_nx;
  logic [TW-1:0]        tap;
  logic [NSTAGE-1:0]    par;
  logic [RW-1:0]        rate_q;
  logic [CW-1:0]        n_act;

  logic signed [DW-1:0] line_q   [NSTAGE];
  logic                 line_push[NSTAGE];
  logic signed [DW-1:0] line_din [NSTAGE];
  logic signed [DW-1:0] coef_tab [TAPS];

  logic signed [AW-1:0] acc_sel;
  logic signed [AW-1:0] wide;
  logic signed [DW-1:0] res;
  logic                 sample_take;
  logic                 busy_in;
  logic                 stage_done;
  logic                 last_stage;
  logic                 mac_on;
  logic                 mac_first;

  assign stg_nx      = stg + SW'(1);
  assign sample_take = in_valid && (st == ENG_IDLE);
  assign busy_in     = in_valid && (st != ENG_IDLE);
  assign stage_done  = (st == ENG_ROUND);
  assign last_stage  = (int'(stg) + 1 == int'(n_act));
  assign mac_on      = (st == ENG_MAC);
  assign mac_first   = (tap == '0);
  assign wide        = round_wide(acc_sel);
  assign res         = wide[DW-1:0];

  for (genvar gi = 0; gi < TAPS; gi++) begin : g_coef
    assign coef_tab[gi] = tap_coef(gi);
  end

  for (genvar gk = 0; gk < NSTAGE; gk++) begin : g_stage
    if (gk == 0) begin : g_head
      assign line_push[gk] = sample_take;
      assign line_din[gk]  = in_data;
    end else begin : g_body
      assign line_push[gk] = stage_done && !last_stage && (int'(stg) == gk - 1);
      assign line_din[gk]  = res;
    end
    bdc_tap_line #(.DW(DW), .TAPS(TAPS)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (flush),
      .push   (line_push[gk]),
      .din    (line_din[gk]),
      .rd_idx (tap),
      .rd_data(line_q[gk])
    );
  end

  bdc_mac_bank #(.DW(DW), .AW(AW), .NACC(NSTAGE)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_all(flush),
    .acc_en (mac_on),
    .first  (mac_first),
    .sel    (stg),
    .mul_a  (line_q[stg]),
    .mul_b  (coef_tab[tap]),
    .acc_out(acc_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st        <= ENG_IDLE;
      stg       <= '0;
      tap       <= '0;
      par       <= '0;
      rate_q    <= rate_sel;
      n_act     <= CW'(stage_count(int'(rate_sel), NSTAGE));
      out_valid <= 1'b0;
      if (!rst_n) out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        ENG_IDLE: begin
          if (in_valid) begin
            par[0] <= ~par[0];
            if (par[0]) begin
              st  <= ENG_MAC;
              stg <= '0;
              tap <= '0;
            end
          end
        end
        ENG_MAC: begin
          if (tap == TW'(TAPS - 1)) st <= ENG_ROUND;
          else tap <= tap + TW'(1);
        end
        ENG_ROUND: begin
          if (last_stage) begin
            out_valid <= 1'b1;
            out_data  <= res;
            st        <= ENG_IDLE;
          end else begin
            par[stg_nx] <= ~par[stg_nx];
            if (par[stg_nx]) begin
              stg <= stg_nx;
              tap <= '0;
              st  <= ENG_MAC;
            end else begin
              st <= ENG_IDLE;
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  // R2: a result leaves only after the selected last stage has rounded
  a_r2_out_from_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(st) == ENG_ROUND) && ($past(int'(stg)) + 1 == $past(int'(n_act))));
  // R3: the rescaled sum always fits the output width
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> fits_out(wide));
  // R5: the engine only works on taps and stages that exist
  a_r5_mac_range: assert property (@(posedge clk) disable iff (!rst_n)
    mac_on |-> (int'(tap) < TAPS) && (int'(stg) < int'(n_act)));
  // R5: the output strobe lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6: the latched rate moves only on flush
  a_r6_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(rate_q));
  // R7: a flush leaves the engine idle with fresh phases
  a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (st == ENG_IDLE) && !out_valid && (par == '0));
  // R9: a sample offered during a pass does not touch the first stage
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_in && !flush) |=> $stable(par[0]));
endmodule

// File: tb/test_binom_decim_cascade.sv
module test_binom_decim_cascade;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 24;
  localparam int TAPS  = 13;
  localparam int NST   = 8;
  localparam int GAP   = 116;
  localparam int WATCH = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [2:0]    rate_sel = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int     checks = 0;
  int     errors = 0;
  int     cur_s = 2;
  int     out_count = 0;
  longint last_out = 0;
  longint weight [TAPS];
  longint hist [NST][TAPS];
  bit     mpar [NST];

  always #(CLK_PERIOD/2) clk = ~clk;

  binom_decim_cascade i_binom_decim_cascade (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s_of(input int code);
    return (code >= 6) ? NST : code + 2;
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < NST; k++) begin
      mpar[k] = 1'b0;
      for (int t = 0; t < TAPS; t++) hist[k][t] = 0;
    end
  endfunction

  function automatic bit model_feed(input longint x, output longint y);
    longint v;
    longint acc;
    v = x;
    y = 0;
    for (int k = 0; k < cur_s; k++) begin
      for (int t = TAPS - 1; t > 0; t--) hist[k][t] = hist[k][t-1];
      hist[k][0] = v;
      mpar[k] = ~mpar[k];
      if (mpar[k]) return 1'b0;
      acc = 0;
      for (int t = 0; t < TAPS; t++) acc += hist[k][t] * weight[t];
      v = (acc + (longint'(1) <<< 24)) >>> 25;
    end
    y = v;
    return 1'b1;
  endfunction

  task automatic send(input longint x, input string req, input bit junk);
    longint ey;
    bit     eo;
    eo = model_feed(x, ey);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int cyc = 0; cyc < GAP - 1; cyc++) begin
      if (eo && cyc == 14 * cur_s) begin
        chk(out_valid === 1'b1, "R5 strobe offset", longint'(out_valid), 1);
        chk($signed(out_data) == ey, req, longint'($signed(out_data)), ey);
        last_out = longint'($signed(out_data));
        out_count++;
      end else if (out_valid !== 1'b0) begin
        chk(1'b0, "R2 stray strobe", cyc, 14 * cur_s);
      end
      if (junk && eo && cyc == 3) begin
        in_valid = 1'b1;
        in_data  = 24'h5A5A5A;
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input int code);
    @(negedge clk);
    rst_n = 1'b0;
    rate_sel = 3'(code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_s = s_of(code);
    model_clear();
  endtask

  task automatic do_flush(input int code);
    @(negedge clk);
    flush = 1'b1;
    rate_sel = 3'(code);
    @(negedge clk);
    flush = 1'b0;
    cur_s = s_of(code);
    model_clear();
    chk(out_valid === 1'b0, "R7 strobe after flush", longint'(out_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid in reset", longint'(out_valid), 0);
    chk(out_data === '0, "R8 out_data in reset", longint'(out_data), 0);
    do_reset(0);
    chk(out_valid === 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
  endtask

  task automatic t_dc_gain();
    do_reset(0);
    out_count = 0;
    for (int n = 0; n < 48; n++) send(1000000, "R4 dc value", 1'b0);
    chk(last_out == 1000000, "R4 settled dc", last_out, 1000000);
    chk(out_count == 12, "R2 outputs at /4", out_count, 12);
  endtask

  task automatic t_impulse();
    do_flush(1);
    out_count = 0;
    send(5000003, "R1 impulse response", 1'b0);
    for (int n = 1; n < 64; n++) send(0, "R1 impulse response", 1'b0);
    chk(out_count == 8, "R2 outputs at /8", out_count, 8);
  endtask

  task automatic t_extremes();
    do_flush(2);
    for (int n = 0; n < 64; n++)
      send((n % 3 == 0) ? -8388608 : ((n % 3 == 1) ? 8388607 : longint'(n * 1234 - 40000)),
           "R3 rounding on extremes", 1'b0);
  endtask

  task automatic t_rate_hold();
    do_reset(0);
    out_count = 0;
    for (int n = 0; n < 8; n++) send(-3000, "R6 data", 1'b0);
    rate_sel = 3'd6;
    for (int n = 0; n < 16; n++) send(n * 777, "R6 data", 1'b0);
    chk(out_count == 6, "R6 rate unchanged without flush", out_count, 6);
  endtask

  task automatic t_flush();
    do_flush(0);
    for (int n = 0; n < 10; n++) send(4000000, "R7 pre-flush", 1'b0);
    do_flush(1);
    out_count = 0;
    for (int n = 0; n < 8; n++) send(0, "R7 post-flush", 1'b0);
    chk(out_count == 1, "R7 first output after D samples", out_count, 1);
    chk(last_out == 0, "R7 history cleared", last_out, 0);
  endtask

  task automatic t_busy_ignore();
    do_flush(0);
    for (int n = 0; n < 24; n++) send(n * 100000 - 1000000, "R9 busy sample ignored", 1'b1);
  endtask

  task automatic t_rates();
    for (int code = 3; code <= 7; code++) begin
      if (code == 6) continue;
      do_flush(code);
      out_count = 0;
      for (int n = 0; n < (1 << s_of(code)); n++) send(-777777, "R2 deep rate value", 1'b0);
      chk(out_count == 1, "R2 one output per D samples", out_count, 1);
    end
  endtask

  initial begin
    int cycles;
    cycles = 0;
    while (cycles < WATCH) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCH);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint row [TAPS];
    for (int i = 0; i < TAPS; i++) row[i] = 0;
    row[0] = 1;
    for (int n = 1; n < TAPS; n++)
      for (int i = n; i > 0; i--) row[i] = row[i] + row[i-1];
    for (int i = 0; i < TAPS; i++) weight[i] = row[i] * 8192;
    model_clear();
    t_reset();
    t_dc_gain();
    t_impulse();
    t_extremes();
    t_rate_hold();
    t_flush();
    t_busy_ignore();
    t_rates();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule